// File: doc/BRIEF.md
# Handshake-Held Bus Target with Local Memory

This block is a simplified parallel-bus target holding a small local memory. A master starts a transaction by pulling an active-low frame strobe low. The first rising edge that sees the strobe low is the address phase: the target takes the address and the direction strobe, then enters one data phase. It answers every address, with no arbitration, bursts or other commands.

In a write, the master puts the word on the data bus and then pulls its own ready strobe low. The target stores the word on that edge and pulls its ready strobe low. In a read, the target fetches the word, turns on its bus driver, and then pulls its ready strobe low. In both cases the ready strobes stay low until the master releases the frame strobe. The target then releases its ready strobe and its driver on the next edge and is ready for a new address phase. The bidirectional data bus is modelled as a separate input, output and output enable.

Top module: `bus_target_mem`

## Requirements
- R1: A synchronous active-low reset leaves the target idle, with `trdy_n` high (1) and `data_oe` low (0), whatever transaction was in progress; memory contents are not reset.
- R2: The address and the direction (`wr_n` = 0 write, 1 read) are taken on the first rising edge in idle at which `frame_n` is 0; changes to `addr` or `wr_n` after that edge have no effect on the transaction.
- R3: In a write data phase, `trdy_n` stays 1 until an edge with `irdy_n` = 0; on that edge the word on `data_in` is stored and `trdy_n` becomes 0.
- R4: In a read, `data_oe` becomes 1 with the stored word on `data_out` one edge after the address phase, while `trdy_n` is still 1; `trdy_n` becomes 0 one edge later.
- R5: Once `trdy_n` is 0, it stays 0 (and in a read `data_oe` stays 1 with `data_out` unchanged) on every edge at which `frame_n` is still 0.
- R6: The edge at which `frame_n` is seen high after `trdy_n` went low returns `trdy_n` to 1 and `data_oe` to 0; the next edge with `frame_n` low is a new address phase.
- R7: If `frame_n` is seen high before the data phase completes, the transaction is abandoned: no word is stored (even if `irdy_n` is 0 on that same edge), `trdy_n` stays 1 and `data_oe` returns to 0.
- R8: `data_oe` is 0 at all times outside a read data phase.
- R9: Only the low 4 address bits select one of 16 words of 8 bits, so addresses that differ only in higher bits reach the same word.
- R10: A write stores the `data_in` value present at the completing edge; later changes of `data_in` do not change the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Transaction frame strobe from the master, active low |
| wr_n | input | 1 | Direction, low for write, high for read; valid in the address phase |
| irdy_n | input | 1 | Master ready, active low |
| addr | input | 8 | Address from the master; valid in the address phase |
| data_in | input | 8 | Bus data as seen by the target (write data) |
| trdy_n | output | 1 | Target ready, active low |
| data_out | output | 8 | Read data the target places on the bus |
| data_oe | output | 1 | Output enable of the target's bus driver |

## Verification
The collision that matters is the master releasing the frame strobe on the same edge that would otherwise complete the data phase: in a write, `frame_n` rises on the edge where `irdy_n` falls. The bench drives both on one edge, then checks that `trdy_n` never went low and reads the word back to show the earlier value is still there. A second overlap is the release edge of one transaction followed at once by the next address phase. Table transactions run back to back to show that the target is idle again after one edge.

// File: rtl/bus_target_pkg.sv
// Shared types for the bus target. Holds the controller state encoding.
package bus_target_pkg;

    // Controller states: idle, write data phase, read fetch, read drive, handshake hold
    typedef enum logic [2:0] {
        TS_IDLE     = 3'd0,
        TS_WR_DATA  = 3'd1,
        TS_RD_FETCH = 3'd2,
        TS_RD_DRIVE = 3'd3,
        TS_HOLD     = 3'd4
    } tgt_state_e;

endpackage

// File: rtl/btgt_fsm.sv
// Transaction controller for the bus target.
// Decodes the address phase, sequences one data phase and holds the
// target ready strobe until the master releases the frame strobe.
// Assumes all strobes are active low and synchronous to clk.
module btgt_fsm
    import bus_target_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic wr_n,
    input  logic irdy_n,
    output logic cap_en,
    output logic mem_we,
    output logic rd_load,
    output logic trdy_n,
    output logic data_oe
);

    tgt_state_e state_q, state_d;
    logic       trdy_n_d, oe_d;

    // Next-state and strobe decode for one edge
    always_comb begin
        state_d  = state_q;
        trdy_n_d = trdy_n;
        oe_d     = data_oe;
        cap_en   = 1'b0;
        mem_we   = 1'b0;
        rd_load  = 1'b0;
        unique case (state_q)
            TS_IDLE: begin
                trdy_n_d = 1'b1;
                oe_d     = 1'b0;
                if (!frame_n) begin
                    cap_en  = 1'b1;
                    state_d = wr_n ? TS_RD_FETCH : TS_WR_DATA;
                end
            end
            TS_WR_DATA: begin
                if (frame_n) begin
                    state_d = TS_IDLE;
                end else if (!irdy_n) begin
                    mem_we   = 1'b1;
                    trdy_n_d = 1'b0;
                    state_d  = TS_HOLD;
                end
            end
            TS_RD_FETCH: begin
                if (frame_n) begin
                    state_d = TS_IDLE;
                end else begin
                    rd_load = 1'b1;
                    oe_d    = 1'b1;
                    state_d = TS_RD_DRIVE;
                end
            end
            TS_RD_DRIVE: begin
                if (frame_n) begin
                    oe_d    = 1'b0;
                    state_d = TS_IDLE;
                end else begin
                    trdy_n_d = 1'b0;
                    state_d  = TS_HOLD;
                end
            end
            TS_HOLD: begin
                if (frame_n) begin
                    trdy_n_d = 1'b1;
                    oe_d     = 1'b0;
                    state_d  = TS_IDLE;
                end
            end
            default: begin
                trdy_n_d = 1'b1;
                oe_d     = 1'b0;
                state_d  = TS_IDLE;
            end
        endcase
    end

    // State and registered strobe update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            trdy_n  <= 1'b1;
            data_oe <= 1'b0;
        end else begin
            state_q <= state_d;
            trdy_n  <= trdy_n_d;
            data_oe <= oe_d;
        end
    end

endmodule

// File: rtl/btgt_dpath.sv
// Address capture and read data register for the bus target.
// Holds the word index from the address phase and the word driven
// during a read. Higher address bits are dropped (aliasing by design).
module btgt_dpath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] data_out
);

    // Mark the address bits above the index as deliberately unused
    generate
        if (ADDR_W > IDX_W) begin : g_hi_bits
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr_in[ADDR_W-1:IDX_W];
        end
    endgenerate

    // Capture the word index on the address phase edge
    always_ff @(posedge clk) begin
        if (cap_en) idx_q <= addr_in[IDX_W-1:0];
    end

    // Load the fetched word into the bus output register
    always_ff @(posedge clk) begin
        if (rd_load) data_out <= rdata;
    end

endmodule

// File: rtl/btgt_mem.sv
// Word memory of the bus target: one synchronous write port and one
// combinational read port sharing the same index. No reset on contents.
module btgt_mem #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [WORDS];

    // Store the write word at the indexed location
    always_ff @(posedge clk) begin
        if (we) words[idx] <= wdata;
    end

    // Present the indexed word to the read register
    assign rdata = words[idx];

endmodule

// File: rtl/bus_target_mem.sv
// Top of the bus target. Connects the controller, the address/data
// registers and the word memory. The bidirectional data bus is split
// into data_in, data_out and data_oe; the pad is outside this block.
module bus_target_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              wr_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              trdy_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    localparam int IDX_W = $clog2(WORDS);

    logic              cap_en, mem_we, rd_load;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] rdata;

    btgt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .wr_n    (wr_n),
        .irdy_n  (irdy_n),
        .cap_en  (cap_en),
        .mem_we  (mem_we),
        .rd_load (rd_load),
        .trdy_n  (trdy_n),
        .data_oe (data_oe)
    );

    btgt_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_dpath (
        .clk      (clk),
        .cap_en   (cap_en),
        .addr_in  (addr),
        .rd_load  (rd_load),
        .rdata    (rdata),
        .idx_q    (idx_q),
        .data_out (data_out)
    );

    btgt_mem #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .idx   (idx_q),
        .wdata (data_in),
        .rdata (rdata)
    );

endmodule

// File: rtl/bus_target_chk.sv
// Protocol checker for the bus target, bound to the top module.
// Watches only the ports; assumes reset is applied from time zero.
module bus_target_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              trdy_n,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out
);

    logic rst_q;

    // Remember the reset level of the previous edge
    always_ff @(posedge clk) rst_q <= rst_n;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_q |-> (trdy_n && !data_oe)); // R1

    AST_OE_LEADS_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> trdy_n); // R4

    AST_READ_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_oe) && !frame_n) |=> !trdy_n); // R4

    AST_TRDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !frame_n) |=> !trdy_n); // R5

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out)); // R5

    AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && frame_n) |=> (trdy_n && !data_oe)); // R6

    AST_NO_READY_UNFRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |=> trdy_n); // R7

endmodule

bind bus_target_mem bus_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .trdy_n   (trdy_n),
    .data_oe  (data_oe),
    .data_out (data_out)
);

// File: tb/bus_target_mem_tb_top.sv
// Self-checking bench for the bus target: a vector table of single
// transactions walked by one loop, then directed reset and corner tests.
module bus_target_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    // Vector: {is_write, addr[7:0], data[7:0]}; for reads data is the expected word
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 8'hA5},
        {1'b1, 8'h0F, 8'h3C},
        {1'b1, 8'h07, 8'h81},
        {1'b1, 8'h1F, 8'hE2},
        {1'b0, 8'h00, 8'hA5},
        {1'b0, 8'h0F, 8'hE2},
        {1'b0, 8'h2F, 8'hE2},
        {1'b0, 8'h07, 8'h81},
        {1'b1, 8'h03, 8'h00},
        {1'b0, 8'h13, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1, wr_n = 1'b1, irdy_n = 1'b1;
    logic [7:0] addr = '0, data_in = '0;
    logic       trdy_n, data_oe;
    logic [7:0] data_out;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    bus_target_mem dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .wr_n     (wr_n),
        .irdy_n   (irdy_n),
        .addr     (addr),
        .data_in  (data_in),
        .trdy_n   (trdy_n),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance one edge and settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_txn(input logic [7:0] a, input logic [7:0] d);
        frame_n = 1'b0; wr_n = 1'b0; addr = a; data_in = d; irdy_n = 1'b1;
        tick();
        check("R3 no ready before irdy", 8'(trdy_n), 8'h1);
        irdy_n = 1'b0;
        tick();
        check("R3 ready on irdy", 8'(trdy_n), 8'h0);
        check("R8 no drive in write", 8'(data_oe), 8'h0);
        tick();
        check("R5 ready held", 8'(trdy_n), 8'h0);
        frame_n = 1'b1; irdy_n = 1'b1; wr_n = 1'b1;
        tick();
        check("R6 ready released", 8'(trdy_n), 8'h1);
    endtask

    task automatic read_txn(input logic [7:0] a, input logic [7:0] exp);
        frame_n = 1'b0; wr_n = 1'b1; addr = a; irdy_n = 1'b1;
        tick();
        check("R8 no drive in address phase", 8'(data_oe), 8'h0);
        tick();
        check("R4 drive on", 8'(data_oe), 8'h1);
        check("R4 read data", data_out, exp);
        check("R4 ready after drive", 8'(trdy_n), 8'h1);
        tick();
        check("R4 ready", 8'(trdy_n), 8'h0);
        irdy_n = 1'b0;
        tick();
        check("R5 ready held", 8'(trdy_n), 8'h0);
        check("R5 data held", data_out, exp);
        frame_n = 1'b1; irdy_n = 1'b1;
        tick();
        check("R6 ready released", 8'(trdy_n), 8'h1);
        check("R6 drive off", 8'(data_oe), 8'h0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(); tick();
        check("R1 trdy in reset", 8'(trdy_n), 8'h1);
        check("R1 oe in reset", 8'(data_oe), 8'h0);
        rst_n = 1'b1;
        tick();

        // Table walk, back to back; covers R3, R4, R5, R6, R9
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][16]) write_txn(VEC[i][15:8], VEC[i][7:0]);
            else            read_txn(VEC[i][15:8], VEC[i][7:0]);
        end

        // R7: frame release on the same edge as irdy in a write
        write_txn(8'h05, 8'h11);
        frame_n = 1'b0; wr_n = 1'b0; addr = 8'h05; data_in = 8'h99; irdy_n = 1'b1;
        tick();
        frame_n = 1'b1; irdy_n = 1'b0;
        tick();
        check("R7 no ready on abort", 8'(trdy_n), 8'h1);
        irdy_n = 1'b1;
        tick();
        check("R7 still idle", 8'(trdy_n), 8'h1);
        read_txn(8'h05, 8'h11);

        // R7: read abandoned right after the driver turned on
        frame_n = 1'b0; wr_n = 1'b1; addr = 8'h05;
        tick(); tick();
        frame_n = 1'b1;
        tick();
        check("R7 read abort drive off", 8'(data_oe), 8'h0);
        check("R7 read abort no ready", 8'(trdy_n), 8'h1);

        // R2: address and direction changed after the address phase
        write_txn(8'h09, 8'hC3);
        frame_n = 1'b0; wr_n = 1'b0; addr = 8'h08; data_in = 8'h5A; irdy_n = 1'b1;
        tick();
        addr = 8'h09; wr_n = 1'b1; irdy_n = 1'b0;
        tick();
        check("R2 still a write", 8'(data_oe), 8'h0);
        check("R2 write completed", 8'(trdy_n), 8'h0);
        frame_n = 1'b1; irdy_n = 1'b1;
        tick();
        read_txn(8'h08, 8'h5A);
        read_txn(8'h09, 8'hC3);

        // R10: data_in changes after the storing edge
        frame_n = 1'b0; wr_n = 1'b0; addr = 8'h0A; data_in = 8'h77; irdy_n = 1'b1;
        tick();
        irdy_n = 1'b0;
        tick();
        data_in = 8'hFF;
        tick();
        frame_n = 1'b1; irdy_n = 1'b1;
        tick();
        read_txn(8'h0A, 8'h77);

        // R1: reset in the middle of a read hold
        frame_n = 1'b0; wr_n = 1'b1; addr = 8'h0A;
        tick(); tick(); tick();
        rst_n = 1'b0;
        tick();
        check("R1 reset mid-transfer trdy", 8'(trdy_n), 8'h1);
        check("R1 reset mid-transfer oe", 8'(data_oe), 8'h0);
        frame_n = 1'b1;
        tick();
        rst_n = 1'b1;
        tick();
        read_txn(8'h0A, 8'h77);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule